// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block drives the read side of a simple display pipeline. It walks a fixed visible raster of 640 columns by 480 rows, one pixel for each advance strobe. For every pixel it issues a word read into a linear framebuffer. It then turns the returned 32-bit word into separate 8-bit red, green and blue levels. Sync timing, porches and memory arbitration belong to neighbouring blocks. This block only receives a start-of-frame strobe and a per-pixel advance strobe, and it emits read requests and colour levels.

Software programs the block through a two-entry word-indexed write port. One entry holds the framebuffer base, of which only the top 11 address bits are kept. The other entry holds a display enable and a flag that turns the picture by 180 degrees. Rows lie 1024 words apart in memory, but only 640 of those words are fetched. The base and the rotation flag are latched at the frame boundary, so a picture is never split between two settings. The enable acts at once.

Top module: `fb_scanout`

## Requirements
- R1: After reset no read is pending, the colour outputs are zero, the display is disabled, the base is zero and rotation is off, so a frame started straight after reset issues no reads.
- R2: A write to index 0 keeps data bits 31:21 as the base, and the lower 21 address bits of every fetch come only from the raster position. A write to index 1 takes bit 0 as display enable and bit 1 as rotation. Writes to indices 2 and 3 change nothing.
- R3: Without rotation, the n-th pixel of a frame (x = n mod 640, y = n div 640) is read at byte address base*2^21 + (y*1024 + x)*4, and x runs fastest.
- R4: With rotation, pixel (x, y) is read from the stored location (639 - x, 479 - y), so the first read of a frame hits the last stored pixel.
- R5: While a frame is active and the display is enabled, each advance strobe issues exactly one read, with rd_en high in the cycle after the strobe. After the last pixel of the frame, strobes issue no reads until the next start-of-frame strobe.
- R6: While the display is disabled, no reads are issued and the colour outputs are zero from the cycle after the disabling write. The raster keeps counting, so enabling again mid-frame resumes reads at the current raster position.
- R7: Base and rotation writes take effect only at the next start-of-frame strobe. The rest of the current frame uses the values latched at its start.
- R8: The word returned RD_LAT cycles after a read gives red from bits 23:16, green from bits 15:8 and blue from bits 7:0. These appear on the outputs one cycle after the word is valid. Bits 31:24 never affect the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Word index of the register written |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Start-of-frame strobe; restarts the raster and latches base and rotation |
| pix_adv | input | 1 | Per-pixel advance strobe |
| rd_en | output | 1 | Framebuffer read request |
| rd_addr | output | 32 | Byte address of the read |
| rd_data | input | 32 | Word returned RD_LAT cycles after a read |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |

## Verification
The assertions assume that frame_start and pix_adv are never high in the same cycle. They also assume that memory returns each word exactly RD_LAT cycles after its request and that no register index outside 0 to 3 exists. The stimulus raises frame_start only while pix_adv is low, and it performs register writes between pixel bursts. Its memory model answers every read with a fixed one-cycle delay, and the word is derived from the address with a top byte that changes on every fetch. To keep runs short, the bench shrinks the raster height to four rows but keeps the full 640-pixel row. Every column boundary and the row stride are therefore still exercised.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_SHIFT  = 2;
    localparam int STRIDE_LOG2 = 10;
    localparam int BASE_BITS   = 11;
    localparam int BASE_LSB    = WORD_W - BASE_BITS;
    localparam int ROW_BITS    = BASE_LSB - STRIDE_LOG2 - BYTE_SHIFT;
    localparam int ROW_LSB     = STRIDE_LOG2 + BYTE_SHIFT;

    localparam logic [1:0] IDX_BASE = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_ROT_BIT = 1;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic rot;
        logic en;
    } ctl_t;

    function automatic rgb_t unpack_word(input logic [WORD_W-1:0] w);
        rgb_t c;
        c.r = w[23:16];
        c.g = w[15:8];
        c.b = w[7:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pix_addr(input logic [BASE_BITS-1:0] base,
                                                  input logic [WORD_W-1:0] col,
                                                  input logic [WORD_W-1:0] row);
        return {base, {BASE_LSB{1'b0}}} | (row << ROW_LSB) | (col << BYTE_SHIFT);
    endfunction

endpackage

// File: rtl/fb_scan_regs.sv
module fb_scan_regs
    import fb_scan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 frame_start,
    output logic                 disp_en,
    output logic [BASE_BITS-1:0] act_base,
    output logic                 act_rot
);

    logic [BASE_BITS-1:0] base_sh;
    ctl_t                 ctl_sh;
    logic                 unused_wdata;

    assign unused_wdata = ^wr_data[BASE_LSB-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_sh  <= '0;
            ctl_sh   <= '0;
            act_base <= '0;
            act_rot  <= 1'b0;
        end else begin
            if (wr_en && wr_idx == IDX_BASE)
                base_sh <= wr_data[WORD_W-1 -: BASE_BITS];
            if (wr_en && wr_idx == IDX_CTRL) begin
                ctl_sh.en  <= wr_data[CTL_EN_BIT];
                ctl_sh.rot <= wr_data[CTL_ROT_BIT];
            end
            if (frame_start) begin
                act_base <= base_sh;
                act_rot  <= ctl_sh.rot;
            end
        end
    end

    assign disp_en = ctl_sh.en;

    // R7: frame settings move only on a frame boundary
    a_r7_latched_at_frame: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(act_base) && $stable(act_rot)));

endmodule

// File: rtl/fb_scan_raster.sv
module fb_scan_raster
    import fb_scan_pkg::*;
#(
    parameter int H_VIS = 640,
    parameter int V_VIS = 480
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 pix_adv,
    input  logic                 disp_en,
    input  logic [BASE_BITS-1:0] base,
    input  logic                 rot,
    output logic                 rd_en,
    output logic [WORD_W-1:0]    rd_addr
);

    localparam int XW = $clog2(H_VIS);
    localparam int YW = $clog2(V_VIS);
    localparam logic [XW-1:0] X_LAST = XW'(H_VIS - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_VIS - 1);

    logic [XW-1:0] x_q, mx;
    logic [YW-1:0] y_q, my;
    logic          scan_q;
    logic [WORD_W-1:0] addr_d;

    always_comb begin
        mx     = rot ? (X_LAST - x_q) : x_q;
        my     = rot ? (Y_LAST - y_q) : y_q;
        addr_d = pix_addr(base, WORD_W'(mx), WORD_W'(my));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            y_q     <= '0;
            scan_q  <= 1'b0;
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= 1'b0;
            if (frame_start) begin
                x_q    <= '0;
                y_q    <= '0;
                scan_q <= 1'b1;
            end else if (pix_adv && scan_q) begin
                rd_en   <= disp_en;
                rd_addr <= addr_d;
                if (x_q == X_LAST) begin
                    x_q <= '0;
                    if (y_q == Y_LAST) scan_q <= 1'b0;
                    else               y_q <= y_q + 1'b1;
                end else begin
                    x_q <= x_q + 1'b1;
                end
            end
        end
    end

    // R6: a disabled display never produces a request
    a_r6_no_read_when_off: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> !rd_en);
    // R5: nothing is fetched outside an active frame
    a_r5_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        (!scan_q && !frame_start) |=> !rd_en);
    // R3: only the visible columns of each row are fetched
    a_r3_col_in_window: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (32'(rd_addr[BYTE_SHIFT +: STRIDE_LOG2]) < H_VIS));
    // R3: only the visible rows are fetched
    a_r3_row_in_window: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (32'(rd_addr[ROW_LSB +: ROW_BITS]) < V_VIS));

endmodule

// File: rtl/fb_scan_unpack.sv
module fb_scan_unpack
    import fb_scan_pkg::*;
#(
    parameter int RD_LAT = 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_data,
    output rgb_t              pix
);

    logic [RD_LAT-1:0] pend;
    logic              ret_vld;
    logic              unused_top;

    assign unused_top = ^rd_data[WORD_W-1:24];

    generate
        if (RD_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) pend <= '0;
                else     pend <= rd_en;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) pend <= '0;
                else     pend <= {pend[RD_LAT-2:0], rd_en};
            end
        end
    endgenerate

    assign ret_vld = pend[RD_LAT-1];

    always_ff @(posedge clk) begin
        if (rst || !disp_en) pix <= '0;
        else if (ret_vld)    pix <= unpack_word(rd_data);
    end

    // R6: disabled display shows black
    a_r6_black_when_off: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> (pix == '0));

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fb_scan_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int V_VIS  = 480,
    parameter int RD_LAT = 1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    input  logic        frame_start,
    input  logic        pix_adv,
    output logic        rd_en,
    output logic [31:0] rd_addr,
    input  logic [31:0] rd_data,
    output logic [7:0]  pix_r,
    output logic [7:0]  pix_g,
    output logic [7:0]  pix_b
);

    logic                 disp_en;
    logic [BASE_BITS-1:0] act_base;
    logic                 act_rot;
    rgb_t                 pix;

    fb_scan_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .wr_idx      (reg_idx),
        .wr_data     (reg_wdata),
        .frame_start (frame_start),
        .disp_en     (disp_en),
        .act_base    (act_base),
        .act_rot     (act_rot)
    );

    fb_scan_raster #(.H_VIS(H_VIS), .V_VIS(V_VIS)) u_raster (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pix_adv     (pix_adv),
        .disp_en     (disp_en),
        .base        (act_base),
        .rot         (act_rot),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr)
    );

    fb_scan_unpack #(.RD_LAT(RD_LAT)) u_unpack (
        .clk     (clk),
        .rst     (rst),
        .disp_en (disp_en),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pix     (pix)
    );

    assign pix_r = pix.r;
    assign pix_g = pix.g;
    assign pix_b = pix.b;

endmodule

// File: tb/sim_fb_scanout.sv
`timescale 1ns/1ps
module sim_fb_scanout;

    localparam int H = 640;
    localparam int V = 4;
    localparam int FRAME = H * V;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_adv = 1'b0;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic [31:0] mem_q = '0;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic [7:0]  junk = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fb_scanout #(.H_VIS(H), .V_VIS(V), .RD_LAT(1)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_adv(pix_adv),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(mem_q),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [7:0] j);
        return {~a[9:2] ^ j, a[9:2], a[19:12], a[9:2] ^ a[19:12] ^ 8'h3C};
    endfunction

    // memory answers one cycle after each request
    always @(posedge clk) if (rd_en) mem_q <= mem_word(rd_addr, junk);

    function automatic logic [31:0] exp_addr(input logic [10:0] b, input bit rot, input int n);
        int x, y;
        x = n % H;
        y = n / H;
        if (rot) begin
            x = H - 1 - x;
            y = V - 1 - y;
        end
        return {b, 21'b0} | (32'(y) << 12) | (32'(x) << 2);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic sof();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // mode 0: reads expected; 1: display off (no reads, black); 2: frame over (no reads)
    task automatic run_px(input logic [10:0] b, input bit rot, input int start,
                          input int count, input int mode, input string req);
        int aerr = 0, cerr = 0;
        logic [31:0] a_act = '0, a_exp = '0, c_act = '0, c_exp = '0;
        logic [31:0] w;
        @(negedge clk);
        pix_adv = 1'b1;
        for (int i = start; i < start + count; i++) begin
            @(negedge clk);
            if (i == start + count - 1) pix_adv = 1'b0;
            if (mode == 0) begin
                if (!rd_en || rd_addr != exp_addr(b, rot, i)) begin
                    if (aerr == 0) begin a_act = rd_en ? rd_addr : 32'hDEAD_0000; a_exp = exp_addr(b, rot, i); end
                    aerr++;
                end
                if (i >= start + 2) begin
                    w = mem_word(exp_addr(b, rot, i - 2), junk);
                    if ({8'h00, pix_r, pix_g, pix_b} != {8'h00, w[23:0]}) begin
                        if (cerr == 0) begin c_act = {8'h00, pix_r, pix_g, pix_b}; c_exp = {8'h00, w[23:0]}; end
                        cerr++;
                    end
                end
            end else begin
                if (rd_en !== 1'b0) begin
                    if (aerr == 0) begin a_act = rd_addr; a_exp = 32'h0; end
                    aerr++;
                end
                if (mode == 1 && {pix_r, pix_g, pix_b} != 24'h0) begin
                    if (cerr == 0) begin c_act = {8'h00, pix_r, pix_g, pix_b}; c_exp = 32'h0; end
                    cerr++;
                end
            end
        end
        chk(aerr == 0, req, (mode == 0) ? "read address sequence" : "unexpected read", a_act, a_exp);
        if (mode == 0) chk(cerr == 0, "R8", "colour unpack", c_act, c_exp);
        if (mode == 1) chk(cerr == 0, "R6", "black while disabled", c_act, c_exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_en == 1'b0, "R1", "rd_en after reset", 32'(rd_en), 32'h0);
        chk({pix_r, pix_g, pix_b} == 24'h0, "R1", "colour after reset",
            {8'h00, pix_r, pix_g, pix_b}, 32'h0);
        sof();
        run_px(11'h0, 1'b0, 0, 16, 1, "R1");
    endtask

    task automatic t_linear_frame();
        wr(2'd0, 32'hA5E0_1234);
        wr(2'd1, 32'h0000_0001);
        sof();
        run_px(11'h52F, 1'b0, 0, FRAME, 0, "R3");
        run_px(11'h52F, 1'b0, FRAME, 6, 2, "R5");
    endtask

    task automatic t_rotated_frame();
        junk = 8'hFF;
        wr(2'd1, 32'h0000_0003);
        sof();
        run_px(11'h52F, 1'b1, 0, FRAME, 0, "R4");
        junk = 8'h00;
    endtask

    task automatic t_disable_resume();
        wr(2'd1, 32'h0000_0000);
        sof();
        run_px(11'h52F, 1'b0, 0, 100, 1, "R6");
        wr(2'd1, 32'h0000_0001);
        run_px(11'h52F, 1'b0, 100, 100, 0, "R6");
    endtask

    task automatic t_deferred_update();
        sof();
        run_px(11'h52F, 1'b0, 0, 50, 0, "R7");
        wr(2'd0, 32'h1FE0_0000);
        wr(2'd1, 32'h0000_0003);
        run_px(11'h52F, 1'b0, 50, 50, 0, "R7");
        sof();
        run_px(11'h0FF, 1'b1, 0, 50, 0, "R7");
    endtask

    task automatic t_decode();
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h0000_0000);
        sof();
        run_px(11'h0FF, 1'b1, 0, 20, 0, "R2");
        wr(2'd0, 32'hFFFF_FFFF);
        sof();
        run_px(11'h7FF, 1'b1, 0, 20, 0, "R2");
    endtask

    initial begin
        t_reset();
        t_linear_frame();
        t_rotated_frame();
        t_disable_resume();
        t_deferred_update();
        t_decode();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule